// File: doc/BRIEF.md
# Congestion-Aware Hybrid Route Selector

This unit makes the routing decision for one tile of a square mesh. The mesh is split into square subnets, and each subnet owns one wireless interface. A header presents the packet's current address and destination address. The unit also reads a congestion map that all interfaces broadcast, with one free bit per virtual channel per interface. One clock later it reports one of four outcomes: a wired hop in XY order, ejection at the destination, a single wireless hop to the destination subnet's interface, or a relay. A relay is a wireless hop from the tile's own interface to a third interface, chosen because it shortens the wired path that remains.

When the unit picks a relay, it raises a done request. The surrounding network uses that request to enter its congestion-broadcast phase. The unit also returns the address where the packet lands after the move, which becomes the packet's new current address. When neither wireless option is usable, the packet takes one wired hop toward its destination and tries the wireless path again at the next tile.

Top module: `hybrid_route_selector`

## Requirements
- R1: An address is {subnet row, subnet column, row within subnet, column within subnet}. With the defaults (8x8 mesh, 2x2 subnets) this is 6 bits: bits [5:2] are the subnet number (row*4+column) and bits [1:0] are {y[0], x[0]}. x grows eastward and y grows northward from tile (0,0) at the bottom left. routeValid is high in exactly the cycle after each cycle in which hdrValid is high.
- R2: When the current and destination subnets match, the route is wired in XY order. It moves east (code 1) or west (code 2) while the x coordinates differ, then north (code 3) or south (code 4). It reports local (code 0) when the addresses are equal. On this route, routeVc is 0, wirelessIf is 0, doneReq is 0, and nextAddr is the neighbour tile (or the current tile when local).
- R3: vcFreeMap bit i*4+v set means VC v of interface i is free. An interface is full when all four of its bits are clear. If the subnets differ and the destination interface is not full, the route is wireless (code 5). wirelessIf is the destination subnet, and routeVc is the lowest-numbered free VC of that interface. nextAddr is that interface's tile, which is the subnet's local index 0. doneReq is 0. The bits of other interfaces do not change this outcome.
- R4: If the destination interface is full, a relay candidate is any interface that is not full, other than the current and destination subnets. Its cost is: wired hops from the current tile to its own subnet's interface, plus 1, plus wired hops from the candidate's interface tile to the destination. A candidate is accepted only if its cost is strictly below the wired distance |dx|+|dy|. Among accepted candidates, the lowest cost wins, and a tie goes to the lowest interface index.
- R5: A relay reports code 5 with wirelessIf set to the chosen interface. routeVc is that interface's lowest free VC, nextAddr is that interface's tile, and doneReq is 1.
- R6: If the destination interface is full and no candidate is accepted, the unit takes one wired XY hop toward the destination, with routeVc 0 and doneReq 0.
- R7: During and right after reset, routeValid and doneReq are 0.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hdrValid | input | 1 | Header addresses and map are valid this cycle |
| curAddr | input | 6 | Current tile address |
| dstAddr | input | 6 | Destination tile address |
| vcFreeMap | input | 64 | Per-interface, per-VC free bits from the congestion broadcast |
| routeValid | output | 1 | Decision valid (one cycle after hdrValid) |
| routeDir | output | 3 | 0 local, 1 east, 2 west, 3 north, 4 south, 5 wireless |
| routeVc | output | 2 | Selected virtual channel |
| wirelessIf | output | 4 | Target interface of a wireless move |
| nextAddr | output | 6 | Address the packet reaches after this move |
| doneReq | output | 1 | Request to raise DONE and enter the broadcast phase |

## Verification
The assertions assume that addresses and the congestion map are sampled only in cycles where hdrValid is high. They also assume that every 6-bit address names a real tile, which always holds for a fully populated power-of-two mesh. The bench changes inputs only on the falling clock edge and holds each header for exactly one cycle, so every decision depends on a single, well-defined input set. The congestion maps are built per scenario so that costs land just above or just below the wired distance, and so that tied candidates are forced into the index rule.

// File: rtl/hrs_pkg.sv
package hrs_pkg;

  typedef enum logic [2:0] {
    DIR_LOCAL = 3'd0,
    DIR_EAST  = 3'd1,
    DIR_WEST  = 3'd2,
    DIR_NORTH = 3'd3,
    DIR_SOUTH = 3'd4,
    DIR_AIR   = 3'd5
  } routeDir_e;

  typedef enum logic [1:0] {
    ACT_WIRED  = 2'd0,
    ACT_DIRECT = 2'd1,
    ACT_RELAY  = 2'd2
  } action_e;

  typedef struct packed {
    logic sameSub;
    logic dstIfFree;
    logic relayFound;
  } pathFlags_t;

  typedef struct packed {
    logic    load;
    action_e act;
    logic    raiseDone;
  } ctrlStrobes_t;

endpackage

// File: rtl/hrs_relay_scan.sv
module hrs_relay_scan #(
  parameter int MESH_DIM = 8,
  parameter int SUB_DIM  = 2,
  localparam int SPS     = MESH_DIM / SUB_DIM,
  localparam int NUM_IF  = SPS * SPS,
  localparam int COORD_W = $clog2(MESH_DIM),
  localparam int SUB_W   = $clog2(NUM_IF),
  localparam int DIST_W  = COORD_W + 2
) (
  input  logic [COORD_W-1:0] curX,
  input  logic [COORD_W-1:0] curY,
  input  logic [COORD_W-1:0] dstX,
  input  logic [COORD_W-1:0] dstY,
  input  logic [SUB_W-1:0]   curSub,
  input  logic [SUB_W-1:0]   dstSub,
  input  logic [NUM_IF-1:0]  ifFull,
  output logic               found,
  output logic [SUB_W-1:0]   bestIf
);

  localparam int LOCAL_W = $clog2(SUB_DIM);

  function automatic logic [DIST_W-1:0] absDiff(input logic [COORD_W-1:0] a,
                                                input logic [COORD_W-1:0] b);
    return (a > b) ? DIST_W'(a - b) : DIST_W'(b - a);
  endfunction

  logic [COORD_W-1:0] ownX, ownY;
  logic [DIST_W-1:0]  ownDist, wiredDist;

  assign ownX      = {curX[COORD_W-1:LOCAL_W], {LOCAL_W{1'b0}}};
  assign ownY      = {curY[COORD_W-1:LOCAL_W], {LOCAL_W{1'b0}}};
  assign ownDist   = absDiff(curX, ownX) + absDiff(curY, ownY);
  assign wiredDist = absDiff(curX, dstX) + absDiff(curY, dstY);

  logic [DIST_W-1:0] candCost [NUM_IF];
  logic [NUM_IF-1:0] candOk;

  for (genvar j = 0; j < NUM_IF; j++) begin : g_cand
    localparam int IX = (j % SPS) * SUB_DIM;
    localparam int IY = (j / SPS) * SUB_DIM;
    assign candCost[j] = ownDist + DIST_W'(1)
                       + absDiff(COORD_W'(IX), dstX) + absDiff(COORD_W'(IY), dstY);
    assign candOk[j]   = !ifFull[j] && (SUB_W'(j) != curSub) && (SUB_W'(j) != dstSub)
                       && (candCost[j] < wiredDist);
  end

  logic [DIST_W-1:0] bestCost;

  always_comb begin
    found    = 1'b0;
    bestIf   = '0;
    bestCost = '1;
    for (int k = 0; k < NUM_IF; k++) begin
      if (candOk[k] && (!found || candCost[k] < bestCost)) begin
        found    = 1'b1;
        bestIf   = SUB_W'(k);
        bestCost = candCost[k];
      end
    end
  end

endmodule

// File: rtl/hrs_datapath.sv
module hrs_datapath
  import hrs_pkg::*;
#(
  parameter int MESH_DIM = 8,
  parameter int SUB_DIM  = 2,
  parameter int NUM_VC   = 4,
  localparam int SPS     = MESH_DIM / SUB_DIM,
  localparam int NUM_IF  = SPS * SPS,
  localparam int COORD_W = $clog2(MESH_DIM),
  localparam int ADDR_W  = 2 * COORD_W,
  localparam int SUB_W   = $clog2(NUM_IF),
  localparam int VC_W    = $clog2(NUM_VC)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        curAddr,
  input  logic [ADDR_W-1:0]        dstAddr,
  input  logic [NUM_IF*NUM_VC-1:0] vcFreeMap,
  input  ctrlStrobes_t             strobes,
  output pathFlags_t               flags,
  output logic [2:0]               routeDir,
  output logic [VC_W-1:0]          routeVc,
  output logic [SUB_W-1:0]         wirelessIf,
  output logic [ADDR_W-1:0]        nextAddr
);

  localparam int LOCAL_W = $clog2(SUB_DIM);
  localparam int SIDE_W  = $clog2(SPS);

  function automatic logic [VC_W-1:0] lowFree(input logic [NUM_VC-1:0] v);
    logic [VC_W-1:0] r;
    r = '0;
    for (int i = NUM_VC - 1; i >= 0; i--) begin
      if (v[i]) r = VC_W'(i);
    end
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] encode(input logic [COORD_W-1:0] x,
                                               input logic [COORD_W-1:0] y);
    return {y[COORD_W-1 -: SIDE_W], x[COORD_W-1 -: SIDE_W],
            y[LOCAL_W-1:0], x[LOCAL_W-1:0]};
  endfunction

  logic [SUB_W-1:0]   curSub, dstSub;
  logic [COORD_W-1:0] curX, curY, dstX, dstY;

  assign curSub = curAddr[ADDR_W-1 -: SUB_W];
  assign dstSub = dstAddr[ADDR_W-1 -: SUB_W];
  assign curX   = {curSub[SIDE_W-1:0], curAddr[LOCAL_W-1:0]};
  assign curY   = {curSub[SUB_W-1 -: SIDE_W], curAddr[2*LOCAL_W-1 -: LOCAL_W]};
  assign dstX   = {dstSub[SIDE_W-1:0], dstAddr[LOCAL_W-1:0]};
  assign dstY   = {dstSub[SUB_W-1 -: SIDE_W], dstAddr[2*LOCAL_W-1 -: LOCAL_W]};

  logic [NUM_IF-1:0] ifFull;
  for (genvar i = 0; i < NUM_IF; i++) begin : g_full
    assign ifFull[i] = ~|vcFreeMap[i*NUM_VC +: NUM_VC];
  end

  logic             relayFound;
  logic [SUB_W-1:0] relayIf;

  hrs_relay_scan #(.MESH_DIM(MESH_DIM), .SUB_DIM(SUB_DIM)) u_scan (
    .curX(curX), .curY(curY), .dstX(dstX), .dstY(dstY),
    .curSub(curSub), .dstSub(dstSub), .ifFull(ifFull),
    .found(relayFound), .bestIf(relayIf)
  );

  assign flags.sameSub    = (curSub == dstSub);
  assign flags.dstIfFree  = !ifFull[dstSub];
  assign flags.relayFound = relayFound;

  routeDir_e          stepDir;
  logic [COORD_W-1:0] stepX, stepY;

  always_comb begin
    stepDir = DIR_LOCAL;
    stepX   = curX;
    stepY   = curY;
    if (dstX > curX) begin
      stepDir = DIR_EAST;  stepX = curX + 1'b1;
    end else if (dstX < curX) begin
      stepDir = DIR_WEST;  stepX = curX - 1'b1;
    end else if (dstY > curY) begin
      stepDir = DIR_NORTH; stepY = curY + 1'b1;
    end else if (dstY < curY) begin
      stepDir = DIR_SOUTH; stepY = curY - 1'b1;
    end
  end

  routeDir_e         dirD;
  logic [VC_W-1:0]   vcD;
  logic [SUB_W-1:0]  ifD;
  logic [ADDR_W-1:0] nextD;

  always_comb begin
    case (strobes.act)
      ACT_DIRECT: begin
        dirD  = DIR_AIR;
        vcD   = lowFree(vcFreeMap[dstSub*NUM_VC +: NUM_VC]);
        ifD   = dstSub;
        nextD = {dstSub, {(2*LOCAL_W){1'b0}}};
      end
      ACT_RELAY: begin
        dirD  = DIR_AIR;
        vcD   = lowFree(vcFreeMap[relayIf*NUM_VC +: NUM_VC]);
        ifD   = relayIf;
        nextD = {relayIf, {(2*LOCAL_W){1'b0}}};
      end
      default: begin
        dirD  = stepDir;
        vcD   = '0;
        ifD   = '0;
        nextD = encode(stepX, stepY);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      routeDir   <= DIR_LOCAL;
      routeVc    <= '0;
      wirelessIf <= '0;
      nextAddr   <= '0;
    end else if (strobes.load) begin
      routeDir   <= dirD;
      routeVc    <= vcD;
      wirelessIf <= ifD;
      nextAddr   <= nextD;
    end
  end

endmodule

// File: rtl/hrs_control.sv
module hrs_control
  import hrs_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         hdrValid,
  input  pathFlags_t   flags,
  output ctrlStrobes_t strobes,
  output logic         routeValid,
  output logic         doneReq
);

  always_comb begin
    strobes.load = hdrValid;
    if (flags.sameSub)         strobes.act = ACT_WIRED;
    else if (flags.dstIfFree)  strobes.act = ACT_DIRECT;
    else if (flags.relayFound) strobes.act = ACT_RELAY;
    else                       strobes.act = ACT_WIRED;
    strobes.raiseDone = (strobes.act == ACT_RELAY);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      routeValid <= 1'b0;
      doneReq    <= 1'b0;
    end else begin
      routeValid <= strobes.load;
      doneReq    <= strobes.load && strobes.raiseDone;
    end
  end

endmodule

// File: rtl/hybrid_route_selector.sv
module hybrid_route_selector
  import hrs_pkg::*;
#(
  parameter int MESH_DIM = 8,
  parameter int SUB_DIM  = 2,
  parameter int NUM_VC   = 4,
  localparam int SPS     = MESH_DIM / SUB_DIM,
  localparam int NUM_IF  = SPS * SPS,
  localparam int ADDR_W  = 2 * $clog2(MESH_DIM),
  localparam int SUB_W   = $clog2(NUM_IF),
  localparam int VC_W    = $clog2(NUM_VC)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     hdrValid,
  input  logic [ADDR_W-1:0]        curAddr,
  input  logic [ADDR_W-1:0]        dstAddr,
  input  logic [NUM_IF*NUM_VC-1:0] vcFreeMap,
  output logic                     routeValid,
  output logic [2:0]               routeDir,
  output logic [VC_W-1:0]          routeVc,
  output logic [SUB_W-1:0]         wirelessIf,
  output logic [ADDR_W-1:0]        nextAddr,
  output logic                     doneReq
);

  pathFlags_t   flags;
  ctrlStrobes_t strobes;

  hrs_control u_ctrl (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .flags(flags),
    .strobes(strobes), .routeValid(routeValid), .doneReq(doneReq)
  );

  hrs_datapath #(.MESH_DIM(MESH_DIM), .SUB_DIM(SUB_DIM), .NUM_VC(NUM_VC)) u_dp (
    .clk(clk), .rstN(rstN), .curAddr(curAddr), .dstAddr(dstAddr),
    .vcFreeMap(vcFreeMap), .strobes(strobes), .flags(flags),
    .routeDir(routeDir), .routeVc(routeVc), .wirelessIf(wirelessIf),
    .nextAddr(nextAddr)
  );

endmodule

// File: rtl/hrs_checker.sv
module hrs_checker #(
  parameter int MESH_DIM = 8,
  parameter int SUB_DIM  = 2,
  parameter int NUM_VC   = 4,
  localparam int SPS     = MESH_DIM / SUB_DIM,
  localparam int NUM_IF  = SPS * SPS,
  localparam int ADDR_W  = 2 * $clog2(MESH_DIM),
  localparam int SUB_W   = $clog2(NUM_IF),
  localparam int VC_W    = $clog2(NUM_VC)
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     hdrValid,
  input logic [ADDR_W-1:0]        curAddr,
  input logic [ADDR_W-1:0]        dstAddr,
  input logic [NUM_IF*NUM_VC-1:0] vcFreeMap,
  input logic                     routeValid,
  input logic [2:0]               routeDir,
  input logic [VC_W-1:0]          routeVc,
  input logic [SUB_W-1:0]         wirelessIf,
  input logic                     doneReq
);

  logic                     prevSame, prevAtDest;
  logic [SUB_W-1:0]         prevDstSub;
  logic [NUM_IF*NUM_VC-1:0] prevMap;

  always_ff @(posedge clk) begin
    prevSame   <= (curAddr[ADDR_W-1 -: SUB_W] == dstAddr[ADDR_W-1 -: SUB_W]);
    prevAtDest <= (curAddr == dstAddr);
    prevDstSub <= dstAddr[ADDR_W-1 -: SUB_W];
    prevMap    <= vcFreeMap;
  end

  p_valid_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |=> routeValid);

  p_no_spurious_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    !hdrValid |=> !routeValid);

  p_same_subnet_wired_r2: assert property (@(posedge clk) disable iff (!rstN)
    (routeValid && prevSame) |-> (routeDir != 3'd5));

  p_local_only_at_dest_r2: assert property (@(posedge clk) disable iff (!rstN)
    (routeValid && routeDir == 3'd0) |-> prevAtDest);

  p_air_vc_free_r3: assert property (@(posedge clk) disable iff (!rstN)
    (routeValid && routeDir == 3'd5) |-> prevMap[wirelessIf*NUM_VC + routeVc]);

  p_done_on_air_r5: assert property (@(posedge clk) disable iff (!rstN)
    doneReq |-> (routeValid && routeDir == 3'd5));

  p_done_not_direct_r5: assert property (@(posedge clk) disable iff (!rstN)
    doneReq |-> (wirelessIf != prevDstSub));

endmodule

bind hybrid_route_selector hrs_checker #(
  .MESH_DIM(MESH_DIM), .SUB_DIM(SUB_DIM), .NUM_VC(NUM_VC)
) u_chk (
  .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .curAddr(curAddr),
  .dstAddr(dstAddr), .vcFreeMap(vcFreeMap), .routeValid(routeValid),
  .routeDir(routeDir), .routeVc(routeVc), .wirelessIf(wirelessIf),
  .doneReq(doneReq)
);

// File: tb/tb_hybrid_route_selector.sv
module tb_hybrid_route_selector;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hdrValid = 1'b0;
  logic [5:0]  curAddr = '0;
  logic [5:0]  dstAddr = '0;
  logic [63:0] vcFreeMap = '1;
  logic        routeValid;
  logic [2:0]  routeDir;
  logic [1:0]  routeVc;
  logic [3:0]  wirelessIf;
  logic [5:0]  nextAddr;
  logic        doneReq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hybrid_route_selector dut (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .curAddr(curAddr),
    .dstAddr(dstAddr), .vcFreeMap(vcFreeMap), .routeValid(routeValid),
    .routeDir(routeDir), .routeVc(routeVc), .wirelessIf(wirelessIf),
    .nextAddr(nextAddr), .doneReq(doneReq)
  );

  function automatic logic [5:0] mk(input int x, input int y);
    logic [2:0] xb, yb;
    xb = 3'(x);
    yb = 3'(y);
    return {yb[2:1], xb[2:1], yb[0], xb[0]};
  endfunction

  function automatic logic [63:0] setIf(input logic [63:0] m, input int idx,
                                        input logic [3:0] v);
    logic [63:0] r;
    r = m;
    r[idx*4 +: 4] = v;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runRoute(input logic [5:0] c, input logic [5:0] d, input logic [63:0] m);
    @(negedge clk);
    hdrValid = 1'b1; curAddr = c; dstAddr = d; vcFreeMap = m;
    @(negedge clk);
    hdrValid = 1'b0;
  endtask

  task automatic expectRoute(input string tag, input int dir, input int vc, input int ifIdx,
                             input logic [5:0] nxt, input bit done);
    chk({tag, " valid"}, 64'(routeValid), 64'd1);
    chk({tag, " dir"},   64'(routeDir),   64'(dir));
    chk({tag, " vc"},    64'(routeVc),    64'(vc));
    chk({tag, " if"},    64'(wirelessIf), 64'(ifIdx));
    chk({tag, " next"},  64'(nextAddr),   64'(nxt));
    chk({tag, " done"},  64'(doneReq),    64'(done));
  endtask

  // R7: reset values
  task automatic testReset();
    @(negedge clk);
    chk("R7 routeValid in reset", 64'(routeValid), 64'd0);
    chk("R7 doneReq in reset", 64'(doneReq), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R7 routeValid after reset", 64'(routeValid), 64'd0);
  endtask

  // R2: wired XY inside one subnet
  task automatic testSameSubnet();
    runRoute(mk(0,0), mk(1,1), '1);
    expectRoute("R2 east first", 1, 0, 0, mk(1,0), 1'b0);
    runRoute(mk(1,1), mk(1,0), '1);
    expectRoute("R2 south", 4, 0, 0, mk(1,0), 1'b0);
    runRoute(mk(3,3), mk(2,3), '1);
    expectRoute("R2 west", 2, 0, 0, mk(2,3), 1'b0);
    runRoute(mk(2,2), mk(2,3), '1);
    expectRoute("R2 north", 3, 0, 0, mk(2,3), 1'b0);
    runRoute(mk(2,3), mk(2,3), 64'd0);
    expectRoute("R2 local", 0, 0, 0, mk(2,3), 1'b0);
  endtask

  // R3: direct wireless, other interfaces' bits irrelevant
  task automatic testDirect();
    runRoute(mk(0,0), mk(7,7), setIf('1, 15, 4'b1100));
    expectRoute("R3 direct", 5, 2, 15, mk(6,6), 1'b0);
    runRoute(mk(0,0), mk(7,7), setIf(64'd0, 15, 4'b1000));
    expectRoute("R3 direct others full", 5, 3, 15, mk(6,6), 1'b0);
  endtask

  // R4/R5: relay selection, tie to lowest index, strict bound
  task automatic testRelay();
    logic [63:0] m;
    m = setIf(setIf('1, 15, 4'b0000), 11, 4'b0010);
    runRoute(mk(0,0), mk(7,7), m);
    expectRoute("R4 tie lowest index R5", 5, 1, 11, mk(6,4), 1'b1);
    m = setIf(setIf('1, 15, 4'b0000), 11, 4'b0000);
    runRoute(mk(0,0), mk(7,7), m);
    expectRoute("R4 next best R5", 5, 0, 14, mk(4,6), 1'b1);
    m = setIf(64'd0, 1, 4'b0100);
    runRoute(mk(0,0), mk(3,3), m);
    expectRoute("R4 cost one below wired R5", 5, 2, 1, mk(2,0), 1'b1);
  endtask

  // R6: fallback to one wired hop
  task automatic testFallback();
    runRoute(mk(0,0), mk(3,3), setIf(64'd0, 15, 4'b1111));
    expectRoute("R6 cost above wired rejected", 1, 0, 0, mk(1,0), 1'b0);
    runRoute(mk(1,1), mk(7,7), setIf(64'd0, 0, 4'b1111));
    expectRoute("R6 own interface not a relay", 1, 0, 0, mk(2,1), 1'b0);
    runRoute(mk(6,7), mk(6,1), 64'd0);
    expectRoute("R6 south toward dst", 4, 0, 0, mk(6,6), 1'b0);
  endtask

  // R1: latency and back-to-back headers
  task automatic testTiming();
    runRoute(mk(0,0), mk(1,0), '1);
    @(negedge clk);
    chk("R1 no valid without header", 64'(routeValid), 64'd0);
    hdrValid = 1'b1; curAddr = mk(0,0); dstAddr = mk(7,7); vcFreeMap = '1;
    @(negedge clk);
    chk("R1 first of pair valid", 64'(routeValid), 64'd1);
    chk("R1 first of pair dir", 64'(routeDir), 64'd5);
    curAddr = mk(3,3); dstAddr = mk(2,2);
    @(negedge clk);
    hdrValid = 1'b0;
    chk("R1 second of pair valid", 64'(routeValid), 64'd1);
    chk("R1 second of pair dir", 64'(routeDir), 64'd2);
    chk("R1 second of pair next", 64'(nextAddr), 64'(mk(2,3)));
  endtask

  initial begin
    testReset();
    testSameSubnet();
    testDirect();
    testRelay();
    testFallback();
    testTiming();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule